// File: doc/BRIEF.md
# Lockable Fast-Interrupt Mask Controller

This block keeps the two interrupt-disable bits of a processor status word. One bit gates normal interrupts and the other gates fast interrupts. It also decides, cycle by cycle, whether a pending fast or normal request is accepted. When a request is accepted, the block emits a one-cycle entry pulse. It sets the mask bits that belong to that entry. It pushes the previous mask state onto a small frame stack, so that an exception return can put that state back. A status output shows whether the innermost active handler is a fast one.

A configuration input locks the fast mask. While the lock is high, software can lower the fast mask but can never raise it. Only reset or a fast entry raises it again. An exception return cannot raise it either. A fast request that arrives while a fast handler runs with its mask set is not accepted. It stays pending until the mask drops. The mask drops either when the return restores the saved state, or when the handler clears the mask itself, which allows nesting. The stack depth is a parameter. Entries are refused while the stack is full.

Top module: `intmask_ctrl`

## Requirements
- R1: After reset, fmask_o and nmask_o are 1, no entry pulse is driven and in_fast_o is 0.
- R2: With fast_lock_i=1, a software write (fmask_wr_i=1) of fmask_wdata_i=0 clears fmask_o on the next clock, provided no entry or stack-popping return occurs in that cycle.
- R3: With fast_lock_i=1, a software write of 1 leaves fmask_o unchanged. An exception return never raises fmask_o, because the restored value is the saved bit ANDed with the current bit. fmask_o rises only through reset or a fast entry.
- R4: With fast_lock_i=0, a software write loads fmask_wdata_i into fmask_o. Writes to the normal mask load nmask_wdata_i in either lock state. Both apply on the next clock when no entry or popping return occurs in that cycle.
- R5: fast_enter_o is high for exactly the cycle in which fast_req_i=1, fmask_o=0, exc_ret_i=0 and the stack is not full. On the next clock both masks are 1 and in_fast_o is 1.
- R6: norm_enter_o is high in a cycle where norm_req_i=1, nmask_o=0, exc_ret_i=0, the stack is not full and no fast entry is taken. On the next clock nmask_o is 1, fmask_o is unchanged and in_fast_o is 0.
- R7: When both requests are eligible in the same cycle, only the fast one is entered. The normal request stays pending and is entered once it is eligible again.
- R8: An entry in the same cycle as a software mask write wins, and the write on either mask is discarded.
- R9: exc_ret_i with a non-empty stack pops the most recent frame, restores both masks from it (subject to R3) and wins over a software write in that cycle. in_fast_o then reflects the enclosing frame. exc_ret_i with an empty stack changes no mask, and software writes in that cycle apply.
- R10: A fast request that arrives while fmask_o=1 inside a fast handler is not entered. If it is held, it is entered in the cycle right after the return that restores fmask_o=0.
- R11: A fast handler that clears fmask_o allows a nested fast entry. No entry is accepted while NEST_DEPTH frames are held.
- R12: No entry pulse is driven in a cycle with exc_ret_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_lock_i | input | 1 | 1: fast mask can only be cleared by software |
| fmask_wr_i | input | 1 | Software write strobe for the fast mask |
| fmask_wdata_i | input | 1 | Value written to the fast mask |
| nmask_wr_i | input | 1 | Software write strobe for the normal mask |
| nmask_wdata_i | input | 1 | Value written to the normal mask |
| fast_req_i | input | 1 | Fast interrupt request, level |
| norm_req_i | input | 1 | Normal interrupt request, level |
| exc_ret_i | input | 1 | Exception-return strobe |
| fmask_o | output | 1 | Current fast-interrupt mask |
| nmask_o | output | 1 | Current normal-interrupt mask |
| fast_enter_o | output | 1 | Fast entry pulse |
| norm_enter_o | output | 1 | Normal entry pulse |
| in_fast_o | output | 1 | Innermost active handler is a fast one |

## Verification
An entry and a software mask write can coincide. The bench provokes this by driving a request together with a write strobe whose data would undo the entry. It then judges that the masks come out set and that the next state matches a model in which the write never happened. A return and a software write can also coincide, and this case is provoked and judged the same way. A per-clock behavioural model with a frame queue predicts every output in every cycle, so a wrong priority between these pairs shows up as a mask mismatch in the following cycle.

// File: rtl/intmask_pkg.sv
package intmask_pkg;
   typedef struct packed {
      logic fmask;
      logic nmask;
      logic fast;
   } ctx_frame_t;
endpackage

// File: rtl/intmask_arb.sv
module intmask_arb (
   input  logic fast_req,
   input  logic norm_req,
   input  logic fmask,
   input  logic nmask,
   input  logic full,
   input  logic ret,
   output logic take_fast,
   output logic take_norm
);
   logic open_gate;

   assign open_gate = ~full & ~ret;
   assign take_fast = open_gate & fast_req & ~fmask;
   assign take_norm = open_gate & norm_req & ~nmask & ~take_fast;
endmodule

// File: rtl/intmask_stack.sv
module intmask_stack
   import intmask_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  ctx_frame_t push_frame,
   input  logic       pop,
   output ctx_frame_t top_frame,
   output logic       full,
   output logic       nonempty
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("intmask_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [CW-1:0]              cnt_q;
   ctx_frame_t [DEPTH-1:0]     slot_q;

   assign full     = (cnt_q == CW'(DEPTH));
   assign nonempty = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (push && !full)
         cnt_q <= cnt_q + 1'b1;
      else if (pop && nonempty)
         cnt_q <= cnt_q - 1'b1;
   end

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_slot
         ctx_frame_t frame_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               frame_r <= '0;
            else if (push && (cnt_q == CW'(k)))
               frame_r <= push_frame;
         end
         assign slot_q[k] = frame_r;
      end
   endgenerate

   always_comb begin
      top_frame = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CW'(i + 1))
            top_frame = slot_q[i];
      end
   end
endmodule

// File: rtl/intmask_regs.sv
module intmask_regs
   import intmask_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock,
   input  logic       take_fast,
   input  logic       take_norm,
   input  logic       ret_ok,
   input  ctx_frame_t ret_frame,
   input  logic       fwe,
   input  logic       fd,
   input  logic       nwe,
   input  logic       nd,
   output logic       fmask,
   output logic       nmask
);
   logic f_next_sw;
   logic f_next_ret;

   assign f_next_sw  = lock ? (fmask & fd) : fd;
   assign f_next_ret = lock ? (fmask & ret_frame.fmask) : ret_frame.fmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmask <= 1'b1;
         nmask <= 1'b1;
      end else if (take_fast) begin
         fmask <= 1'b1;
         nmask <= 1'b1;
      end else if (take_norm) begin
         nmask <= 1'b1;
      end else if (ret_ok) begin
         fmask <= f_next_ret;
         nmask <= ret_frame.nmask;
      end else begin
         if (fwe) fmask <= f_next_sw;
         if (nwe) nmask <= nd;
      end
   end
endmodule

// File: rtl/intmask_ctrl.sv
module intmask_ctrl
   import intmask_pkg::*;
#(
   parameter int NEST_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_lock_i,
   input  logic fmask_wr_i,
   input  logic fmask_wdata_i,
   input  logic nmask_wr_i,
   input  logic nmask_wdata_i,
   input  logic fast_req_i,
   input  logic norm_req_i,
   input  logic exc_ret_i,
   output logic fmask_o,
   output logic nmask_o,
   output logic fast_enter_o,
   output logic norm_enter_o,
   output logic in_fast_o
);
   logic       take_fast, take_norm;
   logic       stk_full, stk_nz, ret_ok;
   ctx_frame_t push_frame, top_frame;
   logic       fmask_q, nmask_q;

   intmask_arb u_arb (
      .fast_req  (fast_req_i),
      .norm_req  (norm_req_i),
      .fmask     (fmask_q),
      .nmask     (nmask_q),
      .full      (stk_full),
      .ret       (exc_ret_i),
      .take_fast (take_fast),
      .take_norm (take_norm)
   );

   assign push_frame = '{fmask: fmask_q, nmask: nmask_q, fast: take_fast};
   assign ret_ok     = exc_ret_i & stk_nz;

   intmask_stack #(.DEPTH(NEST_DEPTH)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (take_fast | take_norm),
      .push_frame (push_frame),
      .pop        (ret_ok),
      .top_frame  (top_frame),
      .full       (stk_full),
      .nonempty   (stk_nz)
   );

   intmask_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock      (fast_lock_i),
      .take_fast (take_fast),
      .take_norm (take_norm),
      .ret_ok    (ret_ok),
      .ret_frame (top_frame),
      .fwe       (fmask_wr_i),
      .fd        (fmask_wdata_i),
      .nwe       (nmask_wr_i),
      .nd        (nmask_wdata_i),
      .fmask     (fmask_q),
      .nmask     (nmask_q)
   );

   assign fmask_o      = fmask_q;
   assign nmask_o      = nmask_q;
   assign fast_enter_o = take_fast;
   assign norm_enter_o = take_norm;
   assign in_fast_o    = stk_nz & top_frame.fast;
endmodule

// File: rtl/intmask_ctrl_chk.sv
module intmask_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic lock,
   input logic fwe,
   input logic fd,
   input logic fast_req,
   input logic eret,
   input logic fmask,
   input logic nmask,
   input logic fast_take,
   input logic norm_take,
   input logic in_fast,
   input logic full,
   input logic nz
);
   AST_LOCK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      lock && !fmask && !fast_take |=> !fmask); // R3
   AST_FAST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      fast_take |=> fmask && nmask && in_fast); // R5
   AST_NORM_ENTRY_KEEPS_F: assert property (@(posedge clk) disable iff (!rst_n)
      norm_take |=> nmask && !in_fast && (fmask == $past(fmask))); // R6
   AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fast_req && !fmask && !full && !eret |-> fast_take && !norm_take); // R7
   AST_NO_ENTRY_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
      eret |-> !fast_take && !norm_take); // R12
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !fast_take && !norm_take); // R11
   AST_UNLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !lock && fwe && !fast_take && !norm_take && !(eret && nz) |=> fmask == $past(fd)); // R4
endmodule

bind intmask_ctrl intmask_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lock      (fast_lock_i),
   .fwe       (fmask_wr_i),
   .fd        (fmask_wdata_i),
   .fast_req  (fast_req_i),
   .eret      (exc_ret_i),
   .fmask     (fmask_o),
   .nmask     (nmask_o),
   .fast_take (fast_enter_o),
   .norm_take (norm_enter_o),
   .in_fast   (in_fast_o),
   .full      (stk_full),
   .nz        (stk_nz)
);

// File: tb/intmask_ctrl_tb_top.sv
`timescale 1ns/1ps
module intmask_ctrl_tb_top;
   localparam int D = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk = 0, fw = 0, fdv = 0, nw = 0, ndv = 0, fr = 0, nr = 0, er = 0;
   logic fmask_o, nmask_o, fast_enter_o, norm_enter_o, in_fast_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int mf = 1, mn = 1;
   int qf[$], qn[$], qk[$];

   always #10 clk = ~clk;

   intmask_ctrl #(.NEST_DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .fast_lock_i(lk),
      .fmask_wr_i(fw), .fmask_wdata_i(fdv),
      .nmask_wr_i(nw), .nmask_wdata_i(ndv),
      .fast_req_i(fr), .norm_req_i(nr), .exc_ret_i(er),
      .fmask_o(fmask_o), .nmask_o(nmask_o),
      .fast_enter_o(fast_enter_o), .norm_enter_o(norm_enter_o),
      .in_fast_o(in_fast_o)
   );

   task automatic chk(string tag, string what, logic act, int exp);
      checks++;
      if (act !== exp[0]) begin
         errors++;
         $display("FAIL %s %s actual %b expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mf = 1; mn = 1;
      qf.delete(); qn.delete(); qk.delete();
   endtask

   task automatic check_all(string tag, int eft, int ent);
      int eif;
      eif = (qk.size() > 0) ? qk[$] : 0;
      chk(tag, "fmask_o", fmask_o, mf);
      chk(tag, "nmask_o", nmask_o, mn);
      chk(tag, "fast_enter_o", fast_enter_o, eft);
      chk(tag, "norm_enter_o", norm_enter_o, ent);
      chk(tag, "in_fast_o", in_fast_o, eif);
   endtask

   // called at a falling edge: drive, check before the rising edge, update the model
   task automatic cyc(string tag, bit l, bit a_fw, bit a_fd, bit a_nw, bit a_nd,
                      bit a_fr, bit a_nr, bit a_er);
      int full, eft, ent;
      lk = l; fw = a_fw; fdv = a_fd; nw = a_nw; ndv = a_nd;
      fr = a_fr; nr = a_nr; er = a_er;
      #5;
      full = (qf.size() >= D);
      eft = (a_fr && mf == 0 && !full && !a_er) ? 1 : 0;
      ent = (a_nr && mn == 0 && !eft && !full && !a_er) ? 1 : 0;
      check_all(tag, eft, ent);
      @(posedge clk);
      if (eft != 0) begin
         qf.push_back(mf); qn.push_back(mn); qk.push_back(1);
         mf = 1; mn = 1;
      end else if (ent != 0) begin
         qf.push_back(mf); qn.push_back(mn); qk.push_back(0);
         mn = 1;
      end else if (a_er && qf.size() > 0) begin
         int sf;
         sf = qf.pop_back();
         mn = qn.pop_back();
         void'(qk.pop_back());
         mf = l ? (sf & mf) : sf;
      end else begin
         if (a_nw) mn = a_nd;
         if (a_fw) mf = l ? (mf & a_fd) : a_fd;
      end
      @(negedge clk);
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      #5;
      check_all("R1", 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      //    tag   lk fw fd nw nd fr nr er
      cyc("R1",   1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R3",   1, 1, 1, 0, 0, 0, 0, 0); // locked write of 1: no change
      cyc("R2",   1, 1, 0, 0, 0, 0, 0, 0); // locked clear
      cyc("R3",   1, 1, 1, 0, 0, 0, 0, 0); // locked set refused
      cyc("R4",   1, 0, 0, 1, 0, 0, 0, 0); // normal mask cleared
      cyc("R7",   1, 0, 0, 0, 0, 1, 1, 0); // both eligible: fast wins
      cyc("R5",   1, 0, 0, 0, 0, 0, 1, 0); // inside fast handler, normal pending
      cyc("R10",  1, 0, 0, 0, 0, 1, 1, 0); // fast during fast handler: held
      cyc("R12",  1, 0, 0, 0, 0, 1, 1, 1); // return: no entry that cycle
      cyc("R10",  1, 0, 0, 0, 0, 1, 1, 0); // held fast taken after return
      cyc("R9",   1, 0, 0, 0, 0, 0, 1, 1); // return again
      cyc("R7",   1, 0, 0, 0, 0, 0, 1, 0); // pending normal now entered
      cyc("R6",   1, 0, 0, 0, 0, 1, 0, 0); // nested fast inside normal
      cyc("R11",  1, 1, 0, 0, 0, 1, 0, 0); // clear inside fast handler
      cyc("R11",  1, 0, 0, 0, 0, 1, 0, 0); // stack full: blocked
      cyc("R9",   1, 0, 0, 0, 0, 0, 0, 1); // pop fast frame
      cyc("R9",   1, 0, 0, 0, 0, 0, 0, 1); // pop normal frame
      cyc("R9",   1, 1, 1, 1, 1, 0, 0, 1); // empty return: writes apply
      cyc("R4",   0, 1, 0, 1, 0, 0, 0, 0); // unlocked clear both
      cyc("R4",   0, 1, 1, 0, 0, 0, 0, 0); // unlocked set
      cyc("R4",   0, 1, 0, 0, 0, 0, 0, 0); // unlocked clear
      cyc("R8",   0, 1, 0, 1, 0, 1, 0, 0); // entry beats writes
      cyc("R9",   0, 1, 1, 1, 1, 0, 0, 1); // return beats writes
      cyc("R4",   0, 1, 1, 1, 0, 0, 0, 0); // fast mask 1, normal 0
      cyc("R6",   0, 0, 0, 0, 0, 0, 1, 0); // normal entry saves fmask=1
      cyc("R4",   0, 1, 0, 0, 0, 0, 0, 0); // clear fmask in handler
      cyc("R9",   0, 0, 0, 0, 0, 0, 0, 1); // unlocked return restores fmask=1
      cyc("R2",   1, 1, 0, 1, 0, 0, 0, 0); // locked clear both
      cyc("R6",   1, 0, 0, 0, 0, 0, 1, 0); // normal entry saves fmask=0
      cyc("R9",   1, 0, 0, 0, 0, 0, 0, 1); // return
      cyc("R4",   0, 1, 1, 0, 0, 0, 0, 0); // set fmask unlocked
      cyc("R6",   1, 0, 0, 0, 0, 0, 1, 0); // normal entry saves fmask=1
      cyc("R2",   1, 1, 0, 0, 0, 0, 0, 0); // locked clear in handler
      cyc("R3",   1, 0, 0, 0, 0, 0, 0, 1); // locked return must not raise
      cyc("R3",   1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R8",   1, 1, 1, 1, 0, 1, 1, 0); // entry with locked writes
      cyc("R11",  1, 1, 0, 0, 0, 0, 0, 0);
      cyc("R11",  1, 0, 0, 0, 0, 1, 0, 0); // nested fast
      cyc("R11",  1, 1, 0, 1, 0, 1, 1, 0); // full: both blocked
      // R1/R3: reset mid-run sets the locked fast mask again
      rst_n = 1'b0;
      #5;
      model_reset();
      check_all("R1", 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1",   1, 0, 0, 0, 0, 1, 1, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule